// File: doc/BRIEF.md
# Burst read termination controller

This block sits on the user side of a 32-bit bus master core. It controls how a burst read ends. A user request carries a data-phase count and two mode bits. When the block accepts the request, it latches the count and the mode bits. It then raises a read request toward the core and holds it there.

Each word the core returns is marked by the core's read-data-valid strobe. That strobe does two jobs: it pushes the word into a small local receive FIFO, and it decrements a remaining-word counter. From that counter the block drives two look-ahead hints back to the core, "two words remain" and "one word remains", so the core can close the burst on time.

When both mode bits are set, the core ends the read when its byte-enable queue runs dry. In that mode both hints stay low. When the core reports the end of the read, the block clears the hints, drops the request and gives the user a one-cycle completion pulse. It then returns to idle.

The controller has three states:
- ST_IDLE: ready for a request.
- ST_BURST: request to the core is active.
- ST_DONE: completion pulse.

It has three transitions:
- ACCEPT, from ST_IDLE to ST_BURST, on `req_valid` while idle.
- FINISH, from ST_BURST to ST_DONE, on `core_rd_done`.
- RETIRE, from ST_DONE to ST_IDLE, unconditionally.

Top module: `burst_rd_term`

## Requirements
- R1: `req_ready` is high only in ST_IDLE. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `core_rd_req` is high until the cycle after `core_rd_done` is sampled. While `core_rd_req` is high, `req_ready` is low, so further requests are refused.
- R2: For an accepted single-phase request in hint mode, `hint_one` is high in the first cycle that `core_rd_req` is high. In that case `hint_two` never rises.
- R3: In hint mode, `hint_two` is high exactly while two words of the burst remain outstanding (length minus words received equals 2). For a two-phase request that is from the first request cycle; otherwise it is after the third-to-last word is received.
- R4: In hint mode, `hint_one` is high exactly while one word remains outstanding. That is after the second-to-last word is received, or from the first request cycle for a single-phase read.
- R5: `hint_one` and `hint_two` are never high together. Both are low in ST_IDLE and once every word of the burst has been received.
- R6: Queue mode is selected when `req_be_sel` and `req_term_sel` are both 1 at acceptance. In queue mode both hints stay low for the whole transaction.
- R7: Hint mode is selected when either select bit is 0 at acceptance. In hint mode the hints follow R3 and R4.
- R8: `rd_done` is high for exactly one cycle, the cycle after `core_rd_done` is sampled during a burst. `req_ready` returns high in the following cycle.
- R9: In the `rd_done` cycle, `core_rd_req`, `hint_one` and `hint_two` are all low.
- R10: `core_be_sel` and `core_term_sel` carry the select bits latched at acceptance. They do not change while `core_rd_req` is high.
- R11: Every word strobed by `core_rd_valid` while the receive FIFO is not full is stored. `rx_data` shows the oldest stored word. `rx_pop` removes it. `rx_empty` is high when nothing is stored.
- R12: A word strobed while the FIFO holds `FIFO_DEPTH` words is dropped, and `rx_full` stays high. The words already stored are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User read request |
| req_len | input | LEN_W | Number of data phases (at least 1) |
| req_be_sel | input | 1 | Byte-enable select for the transaction |
| req_term_sel | input | 1 | Termination select for the transaction |
| req_ready | output | 1 | Block can accept a request |
| core_rd_req | output | 1 | Read request held toward the core |
| core_be_sel | output | 1 | Latched byte-enable select |
| core_term_sel | output | 1 | Latched termination select |
| hint_two | output | 1 | Two words remain |
| hint_one | output | 1 | One word remains |
| core_rd_valid | input | 1 | Core read-data-valid strobe |
| core_rd_data | input | DATA_W | Read word from the core |
| core_rd_done | input | 1 | Core reports end of burst (one cycle) |
| rd_done | output | 1 | One-cycle completion pulse to the user |
| rx_pop | input | 1 | Remove oldest word from receive FIFO |
| rx_data | output | DATA_W | Oldest word in receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_full | output | 1 | Receive FIFO is full |

## Verification
The assertions assume the following about the inputs:
- `req_len` is never zero.
- `core_rd_done` arrives only while `core_rd_req` is high.
- The core never strobes more words than were requested in hint mode.

The stimulus keeps within these limits. It acts as the core and returns exactly the requested count, with random idle cycles between words. It pulses the done input once, only after the last word, and only sends a request while `req_ready` is high.

The sweep covers:
- lengths 1 through 8 under every combination of the two select bits;
- an overfilled FIFO, drained afterwards.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } rt_state_e;
endpackage

// File: rtl/rt_ctrl_fsm.sv
module rt_ctrl_fsm
    import rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic core_done,
    output logic accept,
    output logic finish,
    output logic in_idle,
    output logic in_burst,
    output logic in_done
);
    rt_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_BURST;   // ACCEPT
            ST_BURST: if (core_done) state_d = ST_DONE;    // FINISH
            ST_DONE:  state_d = ST_IDLE;                   // RETIRE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        in_idle  = 1'b0;
        in_burst = 1'b0;
        in_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_idle  = 1'b1;
            ST_BURST: in_burst = 1'b1;
            ST_DONE:  in_done  = 1'b1;
            default:  in_idle  = 1'b1;
        endcase
        accept = in_idle  && req_valid;
        finish = in_burst && core_done;
    end
endmodule

// File: rtl/rt_remain_counter.sv
module rt_remain_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    input  logic             clear,
    input  logic             hint_en,
    output logic             hint_two,
    output logic             hint_one
);
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] rem_m1;

    assign rem_m1 = rem_q - LEN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            hint_one <= 1'b0;
            hint_two <= 1'b0;
        end else if (clear) begin
            rem_q    <= '0;
            hint_one <= 1'b0;
            hint_two <= 1'b0;
        end else if (load) begin
            rem_q    <= len;
            hint_one <= hint_en && (len == LEN_W'(1));
            hint_two <= hint_en && (len == LEN_W'(2));
        end else if (dec && (rem_q != '0)) begin
            rem_q    <= rem_m1;
            hint_one <= hint_en && (rem_m1 == LEN_W'(1));
            hint_two <= hint_en && (rem_m1 == LEN_W'(2));
        end
    end
endmodule

// File: rtl/rt_rx_fifo.sv
module rt_rx_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/burst_rd_term.sv
module burst_rd_term #(
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_be_sel,
    input  logic              req_term_sel,
    output logic              req_ready,
    output logic              core_rd_req,
    output logic              core_be_sel,
    output logic              core_term_sel,
    output logic              hint_two,
    output logic              hint_one,
    input  logic              core_rd_valid,
    input  logic [DATA_W-1:0] core_rd_data,
    input  logic              core_rd_done,
    output logic              rd_done,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              rx_full
);
    logic accept, finish, in_idle, in_burst, in_done;
    logic be_q, term_q;
    logic hint_en;

    rt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .core_done (core_rd_done),
        .accept    (accept),
        .finish    (finish),
        .in_idle   (in_idle),
        .in_burst  (in_burst),
        .in_done   (in_done)
    );

    // Mode bits captured at acceptance, held for the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q   <= 1'b0;
            term_q <= 1'b0;
        end else if (accept) begin
            be_q   <= req_be_sel;
            term_q <= req_term_sel;
        end
    end

    // Hints are used unless both selects request queue-empty termination
    assign hint_en = accept ? !(req_be_sel && req_term_sel) : !(be_q && term_q);

    rt_remain_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .len      (req_len),
        .dec      (in_burst && core_rd_valid),
        .clear    (finish),
        .hint_en  (hint_en),
        .hint_two (hint_two),
        .hint_one (hint_one)
    );

    rt_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (core_rd_valid),
        .wdata (core_rd_data),
        .pop   (rx_pop),
        .rdata (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign req_ready     = in_idle;
    assign core_rd_req   = in_burst;
    assign rd_done       = in_done;
    assign core_be_sel   = be_q;
    assign core_term_sel = term_q;
endmodule

// File: rtl/burst_rd_term_chk.sv
module burst_rd_term_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             req_be_sel,
    input logic             req_term_sel,
    input logic             req_ready,
    input logic             core_rd_req,
    input logic             core_be_sel,
    input logic             core_term_sel,
    input logic             hint_two,
    input logic             hint_one,
    input logic             core_rd_valid,
    input logic             core_rd_done,
    input logic             rd_done,
    input logic             rx_pop,
    input logic             rx_full
);
    assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !core_rd_req);

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> core_rd_req);

    assert_single_hint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == LEN_W'(1) && !(req_be_sel && req_term_sel))
        |=> (hint_one && !hint_two));

    assert_two_to_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_two && core_rd_valid && core_rd_req && !core_rd_done) |=> hint_one);

    assert_hint_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hint_one && hint_two));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!hint_one && !hint_two));

    assert_queue_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && core_be_sel && core_term_sel) |-> (!hint_one && !hint_two));

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && core_rd_done) |=> rd_done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (!rd_done && req_ready));

    assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (!core_rd_req && !hint_one && !hint_two));

    assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_req && $past(core_rd_req)) |-> ($stable(core_be_sel) && $stable(core_term_sel)));

    assert_full_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_pop) |=> rx_full);
endmodule

bind burst_rd_term burst_rd_term_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_len       (req_len),
    .req_be_sel    (req_be_sel),
    .req_term_sel  (req_term_sel),
    .req_ready     (req_ready),
    .core_rd_req   (core_rd_req),
    .core_be_sel   (core_be_sel),
    .core_term_sel (core_term_sel),
    .hint_two      (hint_two),
    .hint_one      (hint_one),
    .core_rd_valid (core_rd_valid),
    .core_rd_done  (core_rd_done),
    .rd_done       (rd_done),
    .rx_pop        (rx_pop),
    .rx_full       (rx_full)
);

// File: tb/tb_burst_rd_term.sv
`timescale 1ns/1ps
module tb_burst_rd_term;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_be_sel, req_term_sel;
    logic [LEN_W-1:0]  req_len;
    logic              req_ready, core_rd_req, core_be_sel, core_term_sel;
    logic              hint_two, hint_one, rd_done;
    logic              core_rd_valid, core_rd_done, rx_pop;
    logic [DATA_W-1:0] core_rd_data, rx_data;
    logic              rx_empty, rx_full;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    burst_rd_term #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_len(req_len),
        .req_be_sel(req_be_sel), .req_term_sel(req_term_sel),
        .req_ready(req_ready), .core_rd_req(core_rd_req),
        .core_be_sel(core_be_sel), .core_term_sel(core_term_sel),
        .hint_two(hint_two), .hint_one(hint_one),
        .core_rd_valid(core_rd_valid), .core_rd_data(core_rd_data),
        .core_rd_done(core_rd_done), .rd_done(rd_done),
        .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input int txn, input int idx);
        return 32'hA000_0000 | (32'(txn) << 8) | 32'(idx);
    endfunction

    // One transaction; the bench plays the core. Inputs change and outputs
    // are sampled at the falling edge.
    task automatic run_txn(input int len, input logic be, input logic ts, input int txn);
        logic qmode;
        int rcv;
        qmode = be && ts;
        check(32'(req_ready), 1, "R1 ready before request");
        req_valid = 1'b1; req_len = LEN_W'(len); req_be_sel = be; req_term_sel = ts;
        @(negedge clk);
        req_valid = 1'b0; req_be_sel = ~be; req_term_sel = ~ts;
        check(32'(core_rd_req), 1, "R1 request raised");
        check(32'(req_ready), 0, "R1 busy refuses");
        if (len == 1 && !qmode) check(32'(hint_one), 1, "R2 single-phase hint_one with request");
        rcv = 0;
        while (rcv < len) begin
            // R3/R4/R6/R7: expected hints from words still outstanding
            check(32'(hint_two), (!qmode && (len - rcv) == 2) ? 1 : 0, qmode ? "R6 hint_two" : "R3 hint_two");
            check(32'(hint_one), (!qmode && (len - rcv) == 1) ? 1 : 0, qmode ? "R6 hint_one" : "R4 hint_one");
            check(32'({core_be_sel, core_term_sel}), 32'({be, ts}), "R10 latched mode");
            if (($urandom % 3) == 0) begin
                core_rd_valid = 1'b0;
            end else begin
                core_rd_valid = 1'b1;
                core_rd_data  = word_of(txn, rcv);
            end
            @(negedge clk);
            if (core_rd_valid) rcv++;
            core_rd_valid = 1'b0;
        end
        check(32'({hint_two, hint_one}), 0, "R5 hints low after last word");
        check(32'(core_rd_req), 1, "R1 request held until done");
        core_rd_done = 1'b1;
        @(negedge clk);
        core_rd_done = 1'b0;
        check(32'(rd_done), 1, "R8 done pulse");
        check(32'({core_rd_req, hint_two, hint_one}), 0, "R9 cleared on done");
        @(negedge clk);
        check(32'(rd_done), 0, "R8 done lasts one cycle");
        check(32'(req_ready), 1, "R8 ready after done");
    endtask

    task automatic drain(input int txn, input int count);
        for (int i = 0; i < count; i++) begin
            check(32'(rx_empty), 0, "R11 data present");
            check(rx_data, word_of(txn, i), "R11 receive order");
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        check(32'(rx_empty), 1, "R11 empty after drain");
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int txn;
        rst_n = 1'b0; req_valid = 1'b0; req_len = '0; req_be_sel = 1'b0; req_term_sel = 1'b0;
        core_rd_valid = 1'b0; core_rd_data = '0; core_rd_done = 1'b0; rx_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'({req_ready, core_rd_req, hint_two, hint_one, rd_done}), 32'b10000, "R1 reset state");
        check(32'({rx_empty, rx_full}), 32'b10, "R11 reset fifo");

        txn = 0;
        for (int mode = 0; mode < 4; mode++) begin
            for (int len = 1; len <= DEPTH; len++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    run_txn(len, mode[1], mode[0], txn);
                    drain(txn, len);
                    txn++;
                end
            end
        end

        // R12: overfill, stored words survive, extras are lost
        run_txn(DEPTH + 3, 1'b0, 1'b1, txn);
        check(32'(rx_full), 1, "R12 full after overfill");
        drain(txn, DEPTH);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule